// File: doc/BRIEF.md
# Cluster Mean Reducer

This block is the reduce stage for a single cluster of an iterative clustering job. Upstream logic hands it only the key-value pairs that belong to its cluster. The key is dropped and the data point is kept. Each signed fixed-point coordinate of the point is added into its own wide running sum, and a running count tracks how many points have arrived.

A plain end-of-iteration strobe closes the iteration. The block then divides every sum by the count, one dimension after another, on a single shared restoring divider. The resulting centroid is offered on a valid/ready output. If no point arrived during the iteration, the previous centroid is offered again, marked by an empty flag.

Back-pressure works as follows. The input is ready only while the block is accumulating. From the end-of-iteration strobe until the result is taken, the input is held not-ready. A result that has been offered stays valid and unchanged until the consumer takes it. Once it is taken, the sums and the count return to zero and the input reopens.

Top module: `centroid_reducer`

## Requirements
- R1: `in_ready` is high exactly while the block is accumulating. It drops in the cycle after `iter_end` is sampled high and stays low until the result has been accepted. `in_ready` and `out_valid` are never high together.
- R2: The key field has no effect: identical points sent with different keys produce identical centroids.
- R3: Each coordinate is a CW-bit two's complement value, and coordinate d sits at bits [d*CW +: CW] of `in_point` and of `out_centroid`. Output coordinate d equals the sum of the accepted coordinates d divided by the number of accepted points, with the quotient truncated toward zero.
- R4: A pair accepted in the same cycle that `iter_end` is sampled is included in that iteration's result.
- R5: If no pair was accepted during the iteration, the block offers the previous result unchanged with `out_empty` = 1. After reset the previous result is all zeros. For any non-empty iteration `out_empty` is 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_centroid` and `out_empty` hold their values.
- R7: After a result is accepted, `in_ready` is high in the next cycle, and the next iteration starts from zero sums and a zero count.
- R8: `iter_end` has no effect while the block is dividing or presenting a result. `in_valid` has no effect while `in_ready` is low.
- R9: After reset, `in_ready` is 1, `out_valid` is 0 and `out_centroid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | Pair accepted when both are high |
| in_key | input | KW | Cluster key of the pair, discarded |
| in_point | input | NDIM*CW | Data point, signed coordinates packed by dimension |
| iter_end | input | 1 | End-of-iteration strobe, sampled while accumulating |
| out_valid | output | 1 | New centroid offered |
| out_ready | input | 1 | Consumer takes the centroid when both are high |
| out_centroid | output | NDIM*CW | Centroid, signed coordinates packed by dimension |
| out_empty | output | 1 | The iteration received no point |

## Verification
The last pair of an iteration and the end-of-iteration strobe can fall in the same cycle. This is the only point where accumulation and the start of the division compete. Every table vector provokes the case by sending its final point in the cycle that raises `iter_end`. The expected mean is computed over all of the vector's points, so a dropped final point shows up as a wrong coordinate or count. A second overlap places stray `in_valid` and `iter_end` pulses inside the division and result phases. It is judged by the value of the following iteration.

// File: rtl/centroid_pkg.sv
package centroid_pkg;
  typedef enum logic [1:0] {
    PH_ACC = 2'd0,
    PH_DIV = 2'd1,
    PH_OUT = 2'd2
  } phase_t;
endpackage

// File: rtl/cr_sum_lane.sv
module cr_sum_lane #(
  parameter int CW    = 16,
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    add,
  input  logic signed [CW-1:0]    pt,
  output logic signed [ACC_W-1:0] sum
);
  localparam int EXT = ACC_W - CW;
  logic signed [ACC_W-1:0] pt_ext;
  assign pt_ext = {{EXT{pt[CW-1]}}, pt};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sum <= '0;
    else if (add)        sum <= sum + pt_ext;
  end
endmodule

// File: rtl/cr_divider.sv
module cr_divider #(
  parameter int CW    = 16,
  parameter int ACC_W = 48,
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [ACC_W-1:0] dividend,
  input  logic [CNT_W-1:0]        divisor,
  output logic                    done,
  output logic signed [CW-1:0]    quotient
);
  localparam int STEP_W = $clog2(ACC_W + 1);

  logic [CNT_W-1:0]  rem;
  logic [ACC_W-1:0]  quo;
  logic [CNT_W-1:0]  dvs;
  logic              neg;
  logic              busy;
  logic [STEP_W-1:0] step;
  logic [CNT_W:0]    shifted;
  logic              fits;

  assign shifted = {rem, quo[ACC_W-1]};
  assign fits    = shifted >= {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      neg  <= 1'b0;
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        neg  <= dividend[ACC_W-1];
        quo  <= dividend[ACC_W-1] ? -dividend : dividend;
        dvs  <= divisor;
        rem  <= '0;
        step <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? CNT_W'(shifted - {1'b0, dvs}) : shifted[CNT_W-1:0];
        quo  <= {quo[ACC_W-2:0], fits};
        step <= step + 1'b1;
        if (step == STEP_W'(ACC_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = neg ? -quo[CW-1:0] : quo[CW-1:0];
endmodule

// File: rtl/centroid_reducer.sv
module centroid_reducer
  import centroid_pkg::*;
#(
  parameter int NDIM  = 3,
  parameter int CW    = 16,
  parameter int KW    = 8,
  parameter int ACC_W = 48,
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [KW-1:0]        in_key,
  input  logic [NDIM*CW-1:0]   in_point,
  input  logic                 iter_end,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NDIM*CW-1:0]   out_centroid,
  output logic                 out_empty
);
  localparam int DIM_W = (NDIM > 1) ? $clog2(NDIM) : 1;
  localparam logic [DIM_W-1:0] LAST_DIM = DIM_W'(NDIM - 1);

  phase_t                  st;
  logic [DIM_W-1:0]        dim;
  logic                    go;
  logic                    take;
  logic                    give;
  logic [CNT_W-1:0]        count_q;
  logic signed [ACC_W-1:0] sums [NDIM];
  logic signed [CW-1:0]    res  [NDIM];
  logic                    div_done;
  logic signed [CW-1:0]    div_q;
  logic                    empty_r;

  assign in_ready  = (st == PH_ACC);
  assign out_valid = (st == PH_OUT);
  assign out_empty = empty_r;
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;

  for (genvar d = 0; d < NDIM; d++) begin : g_lane
    cr_sum_lane #(.CW(CW), .ACC_W(ACC_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (give),
      .add   (take),
      .pt    (in_point[d*CW +: CW]),
      .sum   (sums[d])
    );
    assign out_centroid[d*CW +: CW] = res[d];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || give) count_q <= '0;
    else if (take)      count_q <= count_q + 1'b1;
  end

  cr_divider #(.CW(CW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go),
    .dividend (sums[dim]),
    .divisor  (count_q),
    .done     (div_done),
    .quotient (div_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= PH_ACC;
      dim     <= '0;
      go      <= 1'b0;
      empty_r <= 1'b0;
      for (int d = 0; d < NDIM; d++) res[d] <= '0;
    end else begin
      go <= 1'b0;
      case (st)
        PH_ACC: if (iter_end) begin
          if (count_q == '0 && !take) begin
            empty_r <= 1'b1;
            st      <= PH_OUT;
          end else begin
            empty_r <= 1'b0;
            dim     <= '0;
            go      <= 1'b1;
            st      <= PH_DIV;
          end
        end
        PH_DIV: if (div_done) begin
          res[dim] <= div_q;
          if (dim == LAST_DIM) st <= PH_OUT;
          else begin
            dim <= dim + 1'b1;
            go  <= 1'b1;
          end
        end
        PH_OUT: if (out_ready) st <= PH_ACC;
        default: st <= PH_ACC;
      endcase
    end
  end
endmodule

// File: rtl/reducer_chk.sv
module reducer_chk #(
  parameter int NDIM = 3,
  parameter int CW   = 16,
  parameter int KW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [KW-1:0]      in_key,
  input logic               iter_end,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NDIM*CW-1:0] out_centroid,
  input logic               out_empty
);
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && iter_end |=> !in_ready);

  p_key_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> !$isunknown(in_key));

  p_empty_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_empty |-> $stable(out_centroid));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_centroid) && $stable(out_empty));

  p_reopen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready && !out_valid |=> !in_ready);
endmodule

bind centroid_reducer reducer_chk #(.NDIM(NDIM), .CW(CW), .KW(KW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_key       (in_key),
  .iter_end     (iter_end),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_centroid (out_centroid),
  .out_empty    (out_empty)
);

// File: tb/tb_centroid_reducer.sv
module tb_centroid_reducer;
  localparam int NDIM = 3;
  localparam int CW   = 16;
  localparam int KW   = 8;
  localparam int NV   = 5;

  localparam int VN [NV] = '{2, 3, 4, 2, 1};
  localparam int VK [NV] = '{0, 5, 1, 255, 3};
  localparam int VP [NV][4][3] = '{
    '{'{10, 20, 30},        '{20, 40, -30},       '{0, 0, 0},   '{0, 0, 0}},
    '{'{1, 2, 3},           '{2, 2, 2},           '{4, 2, -7},  '{0, 0, 0}},
    '{'{-3, 100, 0},        '{-4, 101, 0},        '{0, 102, 5}, '{0, 103, 5}},
    '{'{32767, -32768, 7},  '{32767, -32768, -8}, '{0, 0, 0},   '{0, 0, 0}},
    '{'{-5, 6, -7},         '{0, 0, 0},           '{0, 0, 0},   '{0, 0, 0}}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [KW-1:0]      in_key = '0;
  logic [NDIM*CW-1:0] in_point = '0;
  logic               iter_end = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [NDIM*CW-1:0] out_centroid;
  logic               out_empty;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int first_c [NDIM];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  centroid_reducer #(.NDIM(NDIM), .CW(CW), .KW(KW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_point(in_point), .iter_end(iter_end),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_centroid(out_centroid), .out_empty(out_empty)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int coord(input int d);
    return int'($signed(out_centroid[d*CW +: CW]));
  endfunction

  function automatic int vmean(input int v, input int d);
    longint s = 0;
    for (int i = 0; i < VN[v]; i++) s += VP[v][i][d];
    return int'(s / VN[v]);
  endfunction

  task automatic put(input int a, input int b, input int c, input int key, input bit last);
    @(negedge clk);
    in_valid = 1'b1;
    in_key   = KW'(key);
    in_point = {CW'(c), CW'(b), CW'(a)};
    iter_end = last;
    @(negedge clk);
    in_valid = 1'b0;
    iter_end = 1'b0;
  endtask

  task automatic wait_out(input string tag);
    int n = 0;
    while (!out_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(out_valid, tag, longint'(out_valid), 1);
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R7 in_ready after accept", longint'(in_ready), 1);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R9 out_valid", longint'(out_valid), 0);
    check(out_centroid == '0, "R9 centroid", longint'(out_centroid), 0);

    // Table walk: last point of each vector goes with iter_end (R4), keys vary (R2), R3 means
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < VN[v]; i++)
        put(VP[v][i][0], VP[v][i][1], VP[v][i][2], VK[v], i == VN[v] - 1);
      check(!in_ready, "R1 in_ready low after iter_end", longint'(in_ready), 0);
      wait_out("R3 out_valid");
      for (int d = 0; d < NDIM; d++)
        check(coord(d) == vmean(v, d), "R3 R4 coordinate", coord(d), vmean(v, d));
      check(!out_empty, "R5 empty low when points seen", longint'(out_empty), 0);
      accept();
    end

    // R2: same point, two different keys, same result
    put(-5, 6, -7, 200, 1'b1);
    wait_out("R2 out_valid");
    for (int d = 0; d < NDIM; d++) first_c[d] = coord(d);
    accept();
    put(-5, 6, -7, 17, 1'b1);
    wait_out("R2 out_valid");
    for (int d = 0; d < NDIM; d++)
      check(coord(d) == first_c[d], "R2 key ignored", coord(d), first_c[d]);
    accept();

    // R6, R8: back-pressure with stray input and iter_end during division and output
    put(100, 200, 300, 0, 1'b0);
    put(300, 400, 500, 0, 1'b1);
    @(negedge clk);
    in_valid = 1'b1; iter_end = 1'b1; in_point = {CW'(9999), CW'(9999), CW'(9999)};
    @(negedge clk);
    check(!in_ready, "R8 in_ready low while dividing", longint'(in_ready), 0);
    in_valid = 1'b0; iter_end = 1'b0;
    wait_out("R6 out_valid");
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; iter_end = 1'b1;
      @(negedge clk);
      check(out_valid && coord(0) == 200 && coord(1) == 300 && coord(2) == 400,
            "R6 held result", coord(0), 200);
    end
    in_valid = 1'b0; iter_end = 1'b0;
    accept();
    // R7/R8: next iteration sees only its own point
    put(9, 9, 9, 0, 1'b1);
    wait_out("R7 out_valid");
    for (int d = 0; d < NDIM; d++)
      check(coord(d) == 9, "R7 R8 cleared sums", coord(d), 9);
    accept();

    // R5: empty iteration keeps previous centroid
    @(negedge clk);
    iter_end = 1'b1;
    @(negedge clk);
    iter_end = 1'b0;
    wait_out("R5 out_valid");
    check(out_empty, "R5 empty flag", longint'(out_empty), 1);
    for (int d = 0; d < NDIM; d++)
      check(coord(d) == 9, "R5 previous centroid", coord(d), 9);
    accept();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule